// File: doc/BRIEF.md
# Wide Shadow Register File

This block is the general-purpose register store of a core that runs both scalar instructions and 128-bit packed-SIMD instructions. It has 32 entries of 128 bits. Every entry has a scalar view, which is its low 32 bits. The scalar view is not a separate copy: it is a slice of the same storage, so it cannot drift away from the wide value.

Three write sources feed the store:
- The scalar write port takes a 32-bit result and clears the upper 96 bits of the target entry.
- The wide write port stores a full 128-bit packed-SIMD result.
- The lane write port fills one 32-bit lane per beat, so a multi-beat quadword load can assemble an entry one lane at a time.

Two combinational read ports each return the 128-bit value and its low 32 bits. Register 0 reads as zero and cannot be written.

Each write port has a valid strobe but no ready signal. The store accepts a write in every cycle, so a producer never sees back-pressure. A write takes effect at the next rising clock edge.

Top module: `wide_shadow_rf`

## Requirements
- R1: After reset every bit of every entry is zero, so every read port returns zero for every index.
- R2: On each read port the scalar output always equals bits 31:0 of the wide output of that port.
- R3: A scalar write of value Y to register X makes X read as Y zero-extended to 128 bits, so bits 127:32 become zero.
- R4: A wide write stores all 128 bits of its data, including non-zero bits 127:32.
- R5: A lane write with lane select N (0 to 3) replaces bits 32*N+31:32*N of the target entry and leaves the other three lanes unchanged.
- R6: Index 0 reads as zero on both the wide and the scalar output of both read ports.
- R7: A write to index 0 on any port changes no register.
- R8: When several ports write the same register in one cycle, the wide port wins, then the lane port, then the scalar port. Only the winning write takes effect.
- R9: Reads are combinational, and a write becomes visible only after the next rising clock edge, with no same-cycle bypass.
- R10: The two read ports are independent: each returns the entry it addresses, including when both address the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sc_wr_valid | input | 1 | Scalar write strobe |
| sc_wr_idx | input | 5 | Scalar write register index |
| sc_wr_data | input | 32 | Scalar write data, zero-extended on entry |
| wd_wr_valid | input | 1 | Wide write strobe |
| wd_wr_idx | input | 5 | Wide write register index |
| wd_wr_data | input | 128 | Wide write data |
| ln_wr_valid | input | 1 | Lane write strobe |
| ln_wr_idx | input | 5 | Lane write register index |
| ln_wr_lane | input | 2 | Lane select, lane N covers bits 32*N+31:32*N |
| ln_wr_data | input | 32 | Lane write data |
| rd_a_idx | input | 5 | Read port A index |
| rd_a_wide | output | 128 | Read port A, full entry |
| rd_a_scalar | output | 32 | Read port A, low 32 bits |
| rd_b_idx | input | 5 | Read port B index |
| rd_b_wide | output | 128 | Read port B, full entry |
| rd_b_scalar | output | 32 | Read port B, low 32 bits |

## Verification
The assertions assume that every write strobe and index is a known value at each clock edge once reset is released. The stimulus drives all write inputs to defined values in every cycle, including when a strobe is low.

The random mix deliberately draws index 0 and allows address collisions between the three write ports. This reaches the priority and discard paths.

All inputs change on the falling edge. Each port is therefore stable at the rising edge where the entry checks sample it.

// File: rtl/wsrf_pkg.sv
package wsrf_pkg;
  localparam int unsigned WSRF_NREGS = 32;
  localparam int unsigned WSRF_XLEN  = 32;
  localparam int unsigned WSRF_LANES = 4;

  // Source that updates an entry in a given cycle, highest priority last.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SCALAR = 2'd1,
    SRC_LANE   = 2'd2,
    SRC_WIDE   = 2'd3
  } wsrf_src_e;
endpackage

// File: rtl/wsrf_entry.sv
module wsrf_entry
  import wsrf_pkg::*;
#(
  parameter int unsigned IDX   = 1,
  parameter int unsigned XLEN  = WSRF_XLEN,
  parameter int unsigned LANES = WSRF_LANES,
  parameter int unsigned AW    = 5,
  localparam int unsigned WIDE = XLEN * LANES,
  localparam int unsigned LSW  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sc_valid,
  input  logic [AW-1:0]   sc_idx,
  input  logic [XLEN-1:0] sc_data,
  input  logic            wd_valid,
  input  logic [AW-1:0]   wd_idx,
  input  logic [WIDE-1:0] wd_data,
  input  logic            ln_valid,
  input  logic [AW-1:0]   ln_idx,
  input  logic [LSW-1:0]  ln_lane,
  input  logic [XLEN-1:0] ln_data,
  output logic [WIDE-1:0] q
);
  localparam logic [AW-1:0] MY_IDX = AW'(IDX);

  logic      hit_s, hit_w, hit_l;
  wsrf_src_e src;
  logic [WIDE-1:0] nxt;

  assign hit_s = sc_valid && (sc_idx == MY_IDX);
  assign hit_w = wd_valid && (wd_idx == MY_IDX);
  assign hit_l = ln_valid && (ln_idx == MY_IDX);

  always_comb begin
    if (hit_w)      src = SRC_WIDE;
    else if (hit_l) src = SRC_LANE;
    else if (hit_s) src = SRC_SCALAR;
    else            src = SRC_NONE;
  end

  always_comb begin
    nxt = q;
    unique case (src)
      SRC_WIDE:   nxt = wd_data;
      SRC_LANE: begin
        for (int k = 0; k < int'(LANES); k++) begin
          if (ln_lane == LSW'(k)) nxt[k*XLEN +: XLEN] = ln_data;
        end
      end
      SRC_SCALAR: nxt = {{(WIDE-XLEN){1'b0}}, sc_data};
      default:    nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  function automatic logic [WIDE-1:0] lane_mask(input logic [LSW-1:0] s);
    logic [WIDE-1:0] m;
    m = '0;
    for (int k = 0; k < int'(LANES); k++) begin
      if (s == LSW'(k)) m[k*XLEN +: XLEN] = '1;
    end
    return m;
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (q == '0 || !rst_n));
  // R3
  scalar_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_s && !hit_w && !hit_l) |=> (q[WIDE-1:XLEN] == '0 && q[XLEN-1:0] == $past(sc_data)));
  // R8
  wide_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> (q == $past(wd_data)));
  // R5
  lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_l && !hit_w) |=> (((q ^ $past(q)) & ~lane_mask($past(ln_lane))) == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_w && !hit_l && !hit_s) |=> $stable(q));
endmodule

// File: rtl/wsrf_read_port.sv
module wsrf_read_port
  import wsrf_pkg::*;
#(
  parameter int unsigned NREGS = WSRF_NREGS,
  parameter int unsigned XLEN  = WSRF_XLEN,
  parameter int unsigned LANES = WSRF_LANES,
  localparam int unsigned WIDE = XLEN * LANES,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREGS-1:0][WIDE-1:0] rows,
  input  logic [AW-1:0]              idx,
  output logic [WIDE-1:0]            wide,
  output logic [XLEN-1:0]            scalar
);
  assign wide   = (idx == '0) ? '0 : rows[idx];
  assign scalar = wide[XLEN-1:0];

  // R6
  zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == '0) |-> (wide == '0 && scalar == '0));
  // R2
  low_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scalar == rows[idx][XLEN-1:0] || idx == '0);
endmodule

// File: rtl/wide_shadow_rf.sv
module wide_shadow_rf
  import wsrf_pkg::*;
#(
  parameter int unsigned NREGS = WSRF_NREGS,
  parameter int unsigned XLEN  = WSRF_XLEN,
  parameter int unsigned LANES = WSRF_LANES,
  localparam int unsigned WIDE = XLEN * LANES,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned LSW  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sc_wr_valid,
  input  logic [AW-1:0]   sc_wr_idx,
  input  logic [XLEN-1:0] sc_wr_data,
  input  logic            wd_wr_valid,
  input  logic [AW-1:0]   wd_wr_idx,
  input  logic [WIDE-1:0] wd_wr_data,
  input  logic            ln_wr_valid,
  input  logic [AW-1:0]   ln_wr_idx,
  input  logic [LSW-1:0]  ln_wr_lane,
  input  logic [XLEN-1:0] ln_wr_data,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [WIDE-1:0] rd_a_wide,
  output logic [XLEN-1:0] rd_a_scalar,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [WIDE-1:0] rd_b_wide,
  output logic [XLEN-1:0] rd_b_scalar
);
  logic [NREGS-1:0][WIDE-1:0] rows;

  // Index 0 has no storage: it is a constant zero row, so writes to it vanish.
  for (genvar i = 0; i < int'(NREGS); i++) begin : g_row
    if (i == 0) begin : g_zero
      assign rows[i] = '0;
    end else begin : g_store
      wsrf_entry #(
        .IDX(i), .XLEN(XLEN), .LANES(LANES), .AW(AW)
      ) u_entry (
        .clk(clk), .rst_n(rst_n),
        .sc_valid(sc_wr_valid), .sc_idx(sc_wr_idx), .sc_data(sc_wr_data),
        .wd_valid(wd_wr_valid), .wd_idx(wd_wr_idx), .wd_data(wd_wr_data),
        .ln_valid(ln_wr_valid), .ln_idx(ln_wr_idx), .ln_lane(ln_wr_lane),
        .ln_data(ln_wr_data),
        .q(rows[i])
      );
    end
  end

  wsrf_read_port #(.NREGS(NREGS), .XLEN(XLEN), .LANES(LANES)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .rows(rows), .idx(rd_a_idx),
    .wide(rd_a_wide), .scalar(rd_a_scalar)
  );

  wsrf_read_port #(.NREGS(NREGS), .XLEN(XLEN), .LANES(LANES)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .rows(rows), .idx(rd_b_idx),
    .wide(rd_b_wide), .scalar(rd_b_scalar)
  );

  // R7
  zero_row_chk: assert property (@(posedge clk) disable iff (!rst_n) rows[0] == '0);
  // R10
  same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_wide == rd_b_wide));
endmodule

// File: tb/wide_shadow_rf_test.sv
module wide_shadow_rf_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sc_wr_valid = 1'b0;
  logic [4:0]   sc_wr_idx = '0;
  logic [31:0]  sc_wr_data = '0;
  logic         wd_wr_valid = 1'b0;
  logic [4:0]   wd_wr_idx = '0;
  logic [127:0] wd_wr_data = '0;
  logic         ln_wr_valid = 1'b0;
  logic [4:0]   ln_wr_idx = '0;
  logic [1:0]   ln_wr_lane = '0;
  logic [31:0]  ln_wr_data = '0;
  logic [4:0]   rd_a_idx = '0;
  logic [127:0] rd_a_wide;
  logic [31:0]  rd_a_scalar;
  logic [4:0]   rd_b_idx = '0;
  logic [127:0] rd_b_wide;
  logic [31:0]  rd_b_scalar;

  logic [127:0] model [32];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wide_shadow_rf uut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference update: wide beats lane beats scalar; index 0 never changes.
  function automatic void model_apply();
    for (int r = 1; r < 32; r++) begin
      if (wd_wr_valid && wd_wr_idx == 5'(r)) model[r] = wd_wr_data;
      else if (ln_wr_valid && ln_wr_idx == 5'(r)) model[r][ln_wr_lane*32 +: 32] = ln_wr_data;
      else if (sc_wr_valid && sc_wr_idx == 5'(r)) model[r] = {96'd0, sc_wr_data};
    end
  endfunction

  task automatic check_ports(input string tag);
    logic [127:0] ea, eb;
    ea = model[rd_a_idx];
    eb = model[rd_b_idx];
    chk({tag, " R10 port A wide"}, rd_a_wide, ea);
    chk({tag, " R10 port B wide"}, rd_b_wide, eb);
    chk({tag, " R2 port A scalar"}, {96'd0, rd_a_scalar}, {96'd0, rd_a_wide[31:0]});
    chk({tag, " R2 port B scalar"}, {96'd0, rd_b_scalar}, {96'd0, rd_b_wide[31:0]});
  endtask

  // Called at a falling edge with write inputs already set.
  task automatic step(input string tag);
    #1;
    check_ports({tag, " R9 pre-edge"});
    @(posedge clk);
    model_apply();
    @(negedge clk);
    sc_wr_valid = 0; wd_wr_valid = 0; ln_wr_valid = 0;
    #1;
    check_ports(tag);
  endtask

  task automatic dump_all(input string tag);
    for (int r = 0; r < 32; r++) begin
      rd_a_idx = 5'(r); rd_b_idx = 5'(31 - r);
      #1;
      check_ports(tag);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    dump_all("R1 reset");

    // R3: scalar write zero-extends over a wide value
    wd_wr_valid = 1; wd_wr_idx = 5; wd_wr_data = {4{32'hdeadbeef}};
    rd_a_idx = 5; rd_b_idx = 5;
    step("R4 wide write");
    chk("R4 upper bits", rd_a_wide, {4{32'hdeadbeef}});
    sc_wr_valid = 1; sc_wr_idx = 5; sc_wr_data = 32'h12345678;
    step("R3 scalar write");
    chk("R3 zero-extend", rd_a_wide, {96'd0, 32'h12345678});

    // R5: four lane beats assemble an entry, then one lane overwritten
    rd_a_idx = 9;
    for (int n = 0; n < 4; n++) begin
      ln_wr_valid = 1; ln_wr_idx = 9; ln_wr_lane = 2'(n); ln_wr_data = 32'hA0A0_0000 + n;
      step("R5 lane beat");
    end
    chk("R5 assembled", rd_a_wide, {32'hA0A00003, 32'hA0A00002, 32'hA0A00001, 32'hA0A00000});
    ln_wr_valid = 1; ln_wr_idx = 9; ln_wr_lane = 2; ln_wr_data = 32'h5555_5555;
    step("R5 single lane");
    chk("R5 others kept", rd_a_wide, {32'hA0A00003, 32'h55555555, 32'hA0A00001, 32'hA0A00000});

    // R7/R6: writes to index 0 on every port
    wd_wr_valid = 1; wd_wr_idx = 0; wd_wr_data = '1;
    sc_wr_valid = 1; sc_wr_idx = 0; sc_wr_data = '1;
    ln_wr_valid = 1; ln_wr_idx = 0; ln_wr_lane = 3; ln_wr_data = '1;
    rd_a_idx = 0; rd_b_idx = 0;
    step("R7 index 0 write");
    chk("R6 index 0 reads zero", {rd_b_wide[95:0], rd_b_scalar}, 128'd0);
    dump_all("R7 no register touched");

    // R8: collisions
    rd_a_idx = 12; rd_b_idx = 12;
    wd_wr_valid = 1; wd_wr_idx = 12; wd_wr_data = {32'h1, 32'h2, 32'h3, 32'h4};
    sc_wr_valid = 1; sc_wr_idx = 12; sc_wr_data = 32'hffff_ffff;
    ln_wr_valid = 1; ln_wr_idx = 12; ln_wr_lane = 0; ln_wr_data = 32'hbbbb_bbbb;
    step("R8 three-way");
    chk("R8 wide wins", rd_a_wide, {32'h1, 32'h2, 32'h3, 32'h4});
    chk("R8 scalar view", {96'd0, rd_a_scalar}, {96'd0, 32'h4});
    sc_wr_valid = 1; sc_wr_idx = 12; sc_wr_data = 32'hffff_ffff;
    ln_wr_valid = 1; ln_wr_idx = 12; ln_wr_lane = 1; ln_wr_data = 32'hcccc_cccc;
    step("R8 lane over scalar");
    chk("R8 lane wins", rd_a_wide, {32'h1, 32'h2, 32'hcccccccc, 32'h4});

    // Constrained random mix with collisions and index 0
    for (int i = 0; i < 600; i++) begin
      sc_wr_valid = 1'($urandom); sc_wr_idx = 5'($urandom % 8); sc_wr_data = $urandom;
      wd_wr_valid = ($urandom % 3) == 0; wd_wr_idx = 5'($urandom % 8);
      wd_wr_data = {$urandom, $urandom, $urandom, $urandom};
      ln_wr_valid = 1'($urandom); ln_wr_idx = 5'($urandom % 8); ln_wr_lane = 2'($urandom);
      ln_wr_data = $urandom;
      rd_a_idx = (i % 2 == 0) ? sc_wr_idx : 5'($urandom);
      rd_b_idx = (i % 3 == 0) ? rd_a_idx : ln_wr_idx;
      step("R8 random");
    end
    dump_all("R9 final sweep");

    // R1: reset mid-run clears everything
    rst_n = 0;
    for (int r = 0; r < 32; r++) model[r] = '0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    dump_all("R1 re-reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule